// File: doc/BRIEF.md
# Staged Memory Access Bridge

This block sits between a processing core and a word-addressed synchronous memory array. The core never touches the array directly. It loads an address staging register and a data staging register through separate load enables. It then raises a one-cycle read or write command. The bridge runs the array access, brings read data back into the data staging register and pulses a completion flag.

A store is done in a fixed order: load the data register, load the address register, then raise the write command. A load is also done in a fixed order: load the address register, raise the read command, then take the word from the data register once completion is signalled.

The sequencer has two states. In IDLE it accepts commands. A lone read moves it to RD_WAIT (transition IDLE->RD_WAIT). In RD_WAIT the array output is captured and the sequencer always returns to IDLE (transition RD_WAIT->IDLE). A lone write finishes in IDLE and leaves the state unchanged (IDLE->IDLE). So does a conflicting command pair (IDLE->IDLE).

Top module: `mem_stage_bridge`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ar_q`, `dr_q`, `done` and `err` are all zero until the next load or command.
- R2: On a rising edge with `ar_ld` high, `ar_q` takes `ar_din`. With `ar_ld` low, `ar_q` keeps its value.
- R3: On a rising edge with `dr_ld` high, `dr_q` takes `dr_din`, unless a read capture happens at that edge. With neither `dr_ld` nor a capture, `dr_q` keeps its value.
- R4: A lone `rd_cmd` sampled in IDLE reads the word at the `ar_q` value held at that edge. One edge later, `dr_q` holds that word and `done` is 1 for exactly one cycle.
- R5: A lone `wr_cmd` sampled in IDLE stores the `dr_q` value at the `ar_q` location on that edge. `done` is 1 for the one cycle after that edge. `ar_q` and `dr_q` are unchanged by the write.
- R6: When `rd_cmd` and `wr_cmd` are both high on an edge in IDLE, the memory is not written and `done` stays 0. `err` is 1 for the one cycle after that edge.
- R7: On the capture edge of a read, the memory word wins over a simultaneous `dr_ld`.
- R8: Commands sampled in RD_WAIT (the cycle after a read is accepted) are ignored. They cause no memory write and no extra `done`.
- R9: Reset clears the staging registers but leaves the memory contents intact.
- R10: A write stores the `dr_q` value held before its edge, even if `dr_ld` loads a new value at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ar_ld | input | 1 | Load enable for the address staging register |
| ar_din | input | ADDR_W | Value loaded into the address staging register |
| dr_ld | input | 1 | Load enable for the data staging register |
| dr_din | input | DATA_W | Value loaded into the data staging register |
| rd_cmd | input | 1 | Read command, one cycle |
| wr_cmd | input | 1 | Write command, one cycle |
| ar_q | output | ADDR_W | Address staging register |
| dr_q | output | DATA_W | Data staging register |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle flag for a read and write issued together |

## Verification
Each result has a fixed due cycle.
- Register loads and write completion are visible right after the edge that samples them.
- A conflict `err` is visible right after the edge that samples the command pair.
- Read data and read `done` appear one edge later than the read command.

The bench drives inputs and samples outputs 1 ns after each rising edge. At every step it checks both the cycle where a result is due and the cycle after it, so an early, late or stretched pulse is caught. Memory contents are confirmed by reading them back, including after a reset and after ignored or conflicting commands.

// File: rtl/mem_stage_pkg.sv
package mem_stage_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE    = 1'b0,
        SEQ_RD_WAIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/msb_array.sv
module msb_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // no reset: contents survive rst_n
    always_ff @(posedge clk) begin
        if (we) begin
            words[addr] <= wdata;
        end
        if (re) begin
            rdata <= words[addr];
        end
    end
endmodule

// File: rtl/msb_stage_regs.sv
module msb_stage_regs #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_ld,
    input  logic [ADDR_W-1:0] ar_din,
    input  logic              dr_ld,
    input  logic [DATA_W-1:0] dr_din,
    input  logic              cap,
    input  logic [DATA_W-1:0] cap_data,
    output logic [ADDR_W-1:0] ar_q,
    output logic [DATA_W-1:0] dr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_q <= '0;
        end else if (ar_ld) begin
            ar_q <= ar_din;
        end
    end

    // memory capture has priority over a core load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q <= '0;
        end else if (cap) begin
            dr_q <= cap_data;
        end else if (dr_ld) begin
            dr_q <= dr_din;
        end
    end

    // R2
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ar_ld |=> $stable(ar_q));

    // R3
    dr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dr_ld && !cap) |=> $stable(dr_q));

    // R7
    cap_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (dr_q == $past(cap_data)));
endmodule

// File: rtl/msb_sequencer.sv
module msb_sequencer
    import mem_stage_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_cmd,
    input  logic wr_cmd,
    output logic mem_re,
    output logic mem_we,
    output logic cap,
    output logic done,
    output logic err
);
    seq_state_e state_q;
    seq_state_e state_d;
    logic       clash;

    always_comb begin
        mem_re  = 1'b0;
        mem_we  = 1'b0;
        cap     = 1'b0;
        clash   = 1'b0;
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                mem_re = rd_cmd && !wr_cmd;
                mem_we = wr_cmd && !rd_cmd;
                clash  = rd_cmd && wr_cmd;
                if (mem_re) begin
                    state_d = SEQ_RD_WAIT;
                end
            end
            SEQ_RD_WAIT: begin
                cap     = 1'b1;
                state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= mem_we || cap;
            err  <= clash;
        end
    end

    // R4
    rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !done ##1 done);

    // R5
    wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> done);

    // R6
    clash_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && wr_cmd && state_q == SEQ_IDLE) |=> (err && !done));

    // R6
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
endmodule

// File: rtl/mem_stage_bridge.sv
module mem_stage_bridge #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_ld,
    input  logic [ADDR_W-1:0] ar_din,
    input  logic              dr_ld,
    input  logic [DATA_W-1:0] dr_din,
    input  logic              rd_cmd,
    input  logic              wr_cmd,
    output logic [ADDR_W-1:0] ar_q,
    output logic [DATA_W-1:0] dr_q,
    output logic              done,
    output logic              err
);
    logic              mem_re;
    logic              mem_we;
    logic              cap;
    logic [DATA_W-1:0] mem_rdata;

    msb_sequencer u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_cmd (rd_cmd),
        .wr_cmd (wr_cmd),
        .mem_re (mem_re),
        .mem_we (mem_we),
        .cap    (cap),
        .done   (done),
        .err    (err)
    );

    msb_stage_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ar_ld    (ar_ld),
        .ar_din   (ar_din),
        .dr_ld    (dr_ld),
        .dr_din   (dr_din),
        .cap      (cap),
        .cap_data (mem_rdata),
        .ar_q     (ar_q),
        .dr_q     (dr_q)
    );

    msb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (ar_q),
        .wdata (dr_q),
        .rdata (mem_rdata)
    );

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (ar_q == '0 && dr_q == '0 && !done && !err));
endmodule

// File: tb/mem_stage_bridge_bench.sv
module mem_stage_bridge_bench;
    localparam int AW = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ar_ld = 1'b0;
    logic [AW-1:0] ar_din = '0;
    logic          dr_ld = 1'b0;
    logic [DW-1:0] dr_din = '0;
    logic          rd_cmd = 1'b0;
    logic          wr_cmd = 1'b0;
    logic [AW-1:0] ar_q;
    logic [DW-1:0] dr_q;
    logic          done;
    logic          err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mem_stage_bridge #(.ADDR_W(AW), .DATA_W(DW)) u_mem_stage_bridge (
        .clk(clk), .rst_n(rst_n), .ar_ld(ar_ld), .ar_din(ar_din),
        .dr_ld(dr_ld), .dr_din(dr_din), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .ar_q(ar_q), .dr_q(dr_q), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic load_ar(input logic [AW-1:0] a);
        ar_ld = 1'b1; ar_din = a;
        step();
        ar_ld = 1'b0;
    endtask

    task automatic load_dr(input logic [DW-1:0] d);
        dr_ld = 1'b1; dr_din = d;
        step();
        dr_ld = 1'b0;
    endtask

    // R5: data first, then address, then write command
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        load_dr(d);
        load_ar(a);
        wr_cmd = 1'b1;
        step();
        wr_cmd = 1'b0;
        chk(done == 1'b1, "R5 done after write", done, 1);
        chk(ar_q == a && dr_q == d, "R5 staging unchanged", {ar_q, dr_q}, {a, d});
        step();
        chk(done == 1'b0, "R5 done one cycle", done, 0);
    endtask

    // R4: address, read command, then data register
    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        load_ar(a);
        rd_cmd = 1'b1;
        step();
        rd_cmd = 1'b0;
        chk(done == 1'b0, {req, " done not early"}, done, 0);
        step();
        chk(done == 1'b1, {req, " done on capture"}, done, 1);
        chk(dr_q == exp, {req, " read data"}, dr_q, exp);
        step();
        chk(done == 1'b0, {req, " done one cycle"}, done, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        chk(ar_q == '0 && dr_q == '0, "R1 regs clear in reset", {ar_q, dr_q}, 0);
        chk(!done && !err, "R1 flags clear in reset", {done, err}, 0);
        rst_n = 1'b1;
        step();
        chk(ar_q == '0 && dr_q == '0 && !done && !err, "R1 clear after release", {ar_q, dr_q}, 0);
    endtask

    task automatic t_regs();
        load_ar(10'h2A5);
        chk(ar_q == 10'h2A5, "R2 address load", ar_q, 10'h2A5);
        ar_din = 10'h15A;
        step();
        chk(ar_q == 10'h2A5, "R2 address hold", ar_q, 10'h2A5);
        load_dr(16'hC3C3);
        chk(dr_q == 16'hC3C3, "R3 data load", dr_q, 16'hC3C3);
        dr_din = 16'h0F0F;
        step();
        chk(dr_q == 16'hC3C3, "R3 data hold", dr_q, 16'hC3C3);
    endtask

    task automatic t_write_read();
        do_write(10'h011, 16'hBEEF);
        do_write(10'h3FF, 16'h1234);
        do_write(10'h000, 16'hA5A5);
        do_read(10'h011, 16'hBEEF, "R4 read 011");
        do_read(10'h3FF, 16'h1234, "R4 read 3FF");
        do_read(10'h000, 16'hA5A5, "R4 read 000");
    endtask

    task automatic t_conflict();
        load_dr(16'h7777);
        load_ar(10'h011);
        rd_cmd = 1'b1; wr_cmd = 1'b1;
        step();
        rd_cmd = 1'b0; wr_cmd = 1'b0;
        chk(err == 1'b1 && done == 1'b0, "R6 err without done", {err, done}, 2'b10);
        step();
        chk(err == 1'b0 && done == 1'b0, "R6 err one cycle", {err, done}, 0);
        chk(dr_q == 16'h7777, "R6 data reg untouched", dr_q, 16'h7777);
        do_read(10'h011, 16'hBEEF, "R6 memory unchanged");
    endtask

    task automatic t_capture_prio();
        load_ar(10'h3FF);
        rd_cmd = 1'b1;
        step();
        rd_cmd = 1'b0;
        dr_ld = 1'b1; dr_din = 16'h5555;
        step();
        dr_ld = 1'b0;
        chk(dr_q == 16'h1234, "R7 capture beats load", dr_q, 16'h1234);
        step();
    endtask

    task automatic t_busy();
        load_dr(16'h4444);
        load_ar(10'h011);
        rd_cmd = 1'b1;
        step();
        rd_cmd = 1'b0;
        wr_cmd = 1'b1;
        step();
        wr_cmd = 1'b0;
        chk(done == 1'b1 && dr_q == 16'hBEEF, "R8 read completes", dr_q, 16'hBEEF);
        step();
        chk(done == 1'b0, "R8 no extra done", done, 0);
        do_read(10'h011, 16'hBEEF, "R8 ignored write");
    endtask

    task automatic t_same_edge();
        load_dr(16'h1111);
        load_ar(10'h100);
        wr_cmd = 1'b1; dr_ld = 1'b1; dr_din = 16'h2222;
        step();
        wr_cmd = 1'b0; dr_ld = 1'b0;
        chk(done == 1'b1 && dr_q == 16'h2222, "R10 write done, reg loaded", dr_q, 16'h2222);
        step();
        do_read(10'h100, 16'h1111, "R10 old value stored");
    endtask

    task automatic t_reset_keep();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
        chk(ar_q == '0 && dr_q == '0, "R9 regs cleared", {ar_q, dr_q}, 0);
        do_read(10'h3FF, 16'h1234, "R9 memory kept");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        step();
        t_reset();
        t_regs();
        t_write_read();
        t_conflict();
        t_capture_prio();
        t_busy();
        t_same_edge();
        t_reset_keep();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule